// File: doc/BRIEF.md
# Way-Locking Victim Selector

This block chooses which way of a four-way set-associative cache gets the incoming line on a fill. For each allocation it takes the valid bits of the addressed set, that set's index and a lock control bit. It returns the chosen way as a one-hot vector one cycle later and updates a round-robin pointer kept separately for each set. The instruction cache and the data cache each use their own instance, and each instance has its own lock input.

With the lock input low, all four ways compete. An empty way is always taken before an occupied one. When every way is occupied, the set's pointer names the victim and then moves on. With the lock input high, ways 0 and 1 are shielded from eviction: the same algorithm runs, but only over ways 2 and 3. Lines already held in the shielded ways are untouched, so they keep hitting through the normal lookup path. Tag lookup, data storage, fill sequencing and invalidation live elsewhere.

Top module: `way_lock_alloc_sel`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `victim_vld` is 0 and `victim_oh` is all zeros. Every set's round-robin pointer starts at way 0.
- R2: A request sampled with `alloc_req`=1 on a rising edge makes `victim_vld` 1 for the following cycle, with exactly one bit of `victim_oh` set (bit i = way i). In a cycle that follows no request, `victim_vld` is 0 and `victim_oh` is zero.
- R3: With `lock_en`=0, if any bit of `way_valid` is 0 (bit i = way i), the victim is the lowest-numbered way whose valid bit is 0.
- R4: With `lock_en`=0 and all four valid bits 1, the victim is the way named by the set's pointer. The pointer then advances 0,1,2,3,0.
- R5: With `lock_en`=1, `victim_oh` bits 0 and 1 are never set.
- R6: With `lock_en`=1, way 2 is chosen whenever its valid bit is 0. Way 3 is chosen by the empty-way rule only when way 2 is valid and way 3 is not. The valid bits of ways 0 and 1 have no effect on the choice.
- R7: With `lock_en`=1 and ways 2 and 3 both valid, a pointer at 2 or 3 picks that way, and a pointer at 0 or 1 picks way 2. The pointer then moves to the other of ways 2 and 3.
- R8: Each set index has its own pointer. An allocation to one set leaves the pointers of all other sets unchanged.
- R9: A fill that takes an empty way leaves the set's pointer unchanged.
- R10: `lock_en` is sampled with each request. A pointer advanced while locked is used as-is by later unlocked requests, and a pointer advanced while unlocked is used by later locked requests as described in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_req | input | 1 | Allocation strobe, one request per cycle |
| alloc_set | input | SET_W (6) | Index of the set being filled |
| way_valid | input | NUM_WAYS (4) | Valid bit of each way in the addressed set |
| lock_en | input | 1 | Shields ways 0 and 1 from being chosen |
| victim_oh | output | NUM_WAYS (4) | One-hot chosen way, zero when idle |
| victim_vld | output | 1 | High in the cycle after a request |

## Verification
The empty-way rule is tried with valid patterns that contain one, two, three and four empty ways in scattered positions. This separates a lowest-index priority from any other ordering. Fully occupied sets are filled over and over, so the pointer wraps all the way round, and a second set is then used to show that pointers do not leak between sets. Locked requests are tried with patterns that leave ways 0 and 1 empty while ways 2 and 3 are full or partly full; these expose any leak of the lower valid bits into the choice. Switching the lock on and off for one set shows how a pointer value carries across the two modes.

// File: rtl/wsel_pkg.sv
`timescale 1ns/1ps
package wsel_pkg;
  localparam int DFLT_WAYS   = 4;
  localparam int DFLT_LOCKED = 2;
  localparam int DFLT_SETS   = 64;

  // mode the selector is operating in for one request
  typedef enum logic [0:0] {
    MODE_OPEN   = 1'b0,
    MODE_LOCKED = 1'b1
  } wsel_mode_e;
endpackage

// File: rtl/way_pick_logic.sv
`timescale 1ns/1ps
module way_pick_logic
  import wsel_pkg::*;
#(
  parameter int NUM_WAYS    = DFLT_WAYS,
  parameter int LOCKED_WAYS = DFLT_LOCKED,
  localparam int IDX_W      = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] valid,
  input  wsel_mode_e          mode,
  input  logic [IDX_W-1:0]    rr_ptr,
  output logic [IDX_W-1:0]    victim_idx,
  output logic                rr_adv,
  output logic [IDX_W-1:0]    rr_next
);
  localparam logic [IDX_W-1:0] LOW_IDX  = IDX_W'(LOCKED_WAYS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WAYS - 1);

  logic             found;
  logic [IDX_W-1:0] idx_empty;
  logic [IDX_W-1:0] floor_idx;
  logic [IDX_W-1:0] rr_eff;

  // lowest eligible empty way: scan downward so the lowest index wins
  always_comb begin
    found     = 1'b0;
    idx_empty = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid[w] && (mode == MODE_OPEN || w >= LOCKED_WAYS)) begin
        found     = 1'b1;
        idx_empty = IDX_W'(w);
      end
    end
  end

  always_comb begin
    floor_idx  = (mode == MODE_LOCKED) ? LOW_IDX : '0;
    rr_eff     = (mode == MODE_LOCKED && rr_ptr < LOW_IDX) ? LOW_IDX : rr_ptr;
    rr_next    = (rr_eff == LAST_IDX) ? floor_idx : rr_eff + IDX_W'(1);
    victim_idx = found ? idx_empty : rr_eff;
    rr_adv     = !found;
  end
endmodule

// File: rtl/way_rr_table.sv
`timescale 1ns/1ps
module way_rr_table #(
  parameter int NUM_SETS = 64,
  parameter int IDX_W    = 2,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  output logic [IDX_W-1:0] rd_ptr,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [IDX_W-1:0] wr_ptr
);
  logic [IDX_W-1:0] ptr_q [NUM_SETS];
  logic [IDX_W-1:0] ptr_d [NUM_SETS];

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) ptr_d[s] = ptr_q[s];
    if (wr_en) ptr_d[wr_set] = wr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) ptr_q[s] <= '0;
    end else if (wr_en) begin
      for (int s = 0; s < NUM_SETS; s++) ptr_q[s] <= ptr_d[s];
    end
  end

  assign rd_ptr = ptr_q[rd_set];
endmodule

// File: rtl/way_lock_alloc_sel.sv
`timescale 1ns/1ps
module way_lock_alloc_sel
  import wsel_pkg::*;
#(
  parameter int NUM_WAYS    = DFLT_WAYS,
  parameter int LOCKED_WAYS = DFLT_LOCKED,
  parameter int NUM_SETS    = DFLT_SETS,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int IDX_W      = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_req,
  input  logic [SET_W-1:0]    alloc_set,
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic                lock_en,
  output logic [NUM_WAYS-1:0] victim_oh,
  output logic                victim_vld
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  wsel_mode_e          mode;
  logic [IDX_W-1:0]    cur_ptr;
  logic [IDX_W-1:0]    pick_idx;
  logic                pick_rr;
  logic [IDX_W-1:0]    ptr_next;
  logic [NUM_WAYS-1:0] pick_oh;
  logic [NUM_WAYS-1:0] oh_d;
  logic [NUM_WAYS-1:0] oh_q;
  logic                vld_d;
  logic                vld_q;

  assign mode = lock_en ? MODE_LOCKED : MODE_OPEN;

  way_rr_table #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_set (alloc_set),
    .rd_ptr (cur_ptr),
    .wr_en  (alloc_req && pick_rr),
    .wr_set (alloc_set),
    .wr_ptr (ptr_next)
  );

  way_pick_logic #(.NUM_WAYS(NUM_WAYS), .LOCKED_WAYS(LOCKED_WAYS)) u_pick (
    .valid      (way_valid),
    .mode       (mode),
    .rr_ptr     (cur_ptr),
    .victim_idx (pick_idx),
    .rr_adv     (pick_rr),
    .rr_next    (ptr_next)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_dec
    assign pick_oh[w] = (pick_idx == IDX_W'(w));
  end

  always_comb begin
    vld_d = alloc_req;
    oh_d  = alloc_req ? pick_oh : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      oh_q  <= '0;
    end else begin
      vld_q <= vld_d;
      oh_q  <= oh_d;
    end
  end

  assign victim_oh  = oh_q;
  assign victim_vld = vld_q;
endmodule

// File: rtl/way_lock_alloc_chk.sv
`timescale 1ns/1ps
module way_lock_alloc_chk #(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_req,
  input logic [SET_W-1:0]    alloc_set,
  input logic [NUM_WAYS-1:0] way_valid,
  input logic                lock_en,
  input logic [NUM_WAYS-1:0] victim_oh,
  input logic                victim_vld
);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_vld |-> victim_oh == '0);

  // R2
  req_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> victim_vld);

  // R2
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> !victim_vld);

  // R2
  one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_vld |-> $countones(victim_oh) == 1);

  // R3
  open_empty0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !lock_en && !way_valid[0]) |=> victim_oh[0]);

  // R5
  locked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && lock_en) |=> victim_oh[1:0] == 2'b00);

  // R6
  locked_empty2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && lock_en && !way_valid[2]) |=> victim_oh[2]);
endmodule

bind way_lock_alloc_sel way_lock_alloc_chk #(
  .NUM_WAYS (NUM_WAYS),
  .SET_W    (SET_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .alloc_req  (alloc_req),
  .alloc_set  (alloc_set),
  .way_valid  (way_valid),
  .lock_en    (lock_en),
  .victim_oh  (victim_oh),
  .victim_vld (victim_vld)
);

// File: tb/test_way_lock_alloc_sel.sv
`timescale 1ns/1ps
module test_way_lock_alloc_sel;
  logic       clk;
  logic       rst_n;
  logic       alloc_req;
  logic [5:0] alloc_set;
  logic [3:0] way_valid;
  logic       lock_en;
  logic [3:0] victim_oh;
  logic       victim_vld;

  int total;
  int bad;
  bit done;

  way_lock_alloc_sel i_way_lock_alloc_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_req),
    .alloc_set  (alloc_set),
    .way_valid  (way_valid),
    .lock_en    (lock_en),
    .victim_oh  (victim_oh),
    .victim_vld (victim_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; inputs set at a falling edge, result read at the next falling edge
  task automatic alloc(input logic [5:0] s, input logic [3:0] v, input logic lk,
                       input logic [3:0] exp_oh, input string req);
    @(negedge clk);
    alloc_req = 1'b1;
    alloc_set = s;
    way_valid = v;
    lock_en   = lk;
    @(negedge clk);
    alloc_req = 1'b0;
    check({req, " vld"}, 32'(victim_vld), 32'd1);
    check({req, " way"}, 32'(victim_oh), 32'(exp_oh));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; alloc_req = 1'b0; alloc_set = '0; way_valid = '0; lock_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 vld in reset", 32'(victim_vld), 32'd0);
    check("R1 oh in reset", 32'(victim_oh), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 vld after reset", 32'(victim_vld), 32'd0);
    check("R1 oh after reset", 32'(victim_oh), 32'd0);
  endtask

  task automatic t_open_empty;
    alloc(6'd1, 4'b0000, 1'b0, 4'b0001, "R3 all empty");
    alloc(6'd1, 4'b0001, 1'b0, 4'b0010, "R3 w0 full");
    alloc(6'd1, 4'b0011, 1'b0, 4'b0100, "R3 w0w1 full");
    alloc(6'd1, 4'b0111, 1'b0, 4'b1000, "R3 only w3 empty");
    alloc(6'd1, 4'b1010, 1'b0, 4'b0001, "R3 scattered a");
    alloc(6'd1, 4'b1101, 1'b0, 4'b0010, "R3 scattered b");
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R2 idle vld", 32'(victim_vld), 32'd0);
    check("R2 idle oh", 32'(victim_oh), 32'd0);
  endtask

  task automatic t_round_robin;
    alloc(6'd5, 4'b1111, 1'b0, 4'b0001, "R4 rr first");
    alloc(6'd5, 4'b1111, 1'b0, 4'b0010, "R4 rr second");
    alloc(6'd5, 4'b1111, 1'b0, 4'b0100, "R4 rr third");
    alloc(6'd5, 4'b1111, 1'b0, 4'b1000, "R4 rr fourth");
    alloc(6'd5, 4'b1111, 1'b0, 4'b0001, "R4 rr wrap");
    // pointer of set 5 now at 1
    alloc(6'd5, 4'b1110, 1'b0, 4'b0001, "R9 empty fill");
    alloc(6'd5, 4'b1111, 1'b0, 4'b0010, "R9 pointer kept");
    alloc(6'd9, 4'b1111, 1'b0, 4'b0001, "R8 other set fresh");
    alloc(6'd5, 4'b1111, 1'b0, 4'b0100, "R8 set 5 unaffected");
  endtask

  task automatic t_locked;
    alloc(6'd12, 4'b0000, 1'b1, 4'b0100, "R5 R6 all empty");
    alloc(6'd12, 4'b0100, 1'b1, 4'b1000, "R6 w2 full w3 empty");
    alloc(6'd12, 4'b1000, 1'b1, 4'b0100, "R6 w3 full w2 empty");
    alloc(6'd12, 4'b1011, 1'b1, 4'b0100, "R6 w2 before w3");
    alloc(6'd12, 4'b1100, 1'b1, 4'b0100, "R6 low empties ignored");
    alloc(6'd12, 4'b1111, 1'b1, 4'b1000, "R7 toggle to 3");
    alloc(6'd12, 4'b1111, 1'b1, 4'b0100, "R7 toggle back to 2");
    alloc(6'd12, 4'b1101, 1'b1, 4'b1000, "R5 R7 w1 empty ignored");
  endtask

  task automatic t_mode_switch;
    alloc(6'd20, 4'b1111, 1'b0, 4'b0001, "R10 open 0");
    alloc(6'd20, 4'b1111, 1'b0, 4'b0010, "R10 open 1");
    alloc(6'd20, 4'b1111, 1'b0, 4'b0100, "R10 open 2");
    alloc(6'd20, 4'b1111, 1'b1, 4'b1000, "R10 locked uses ptr 3");
    alloc(6'd20, 4'b1111, 1'b0, 4'b0100, "R10 open after lock");
    alloc(6'd20, 4'b1111, 1'b0, 4'b1000, "R10 open continues");
    alloc(6'd20, 4'b1111, 1'b0, 4'b0001, "R10 open wraps");
    alloc(6'd20, 4'b1111, 1'b1, 4'b0100, "R7 ptr 1 maps to 2");
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    t_reset();
    t_open_empty();
    t_idle();
    t_round_robin();
    t_locked();
    t_idle();
    t_mode_switch();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule